// File: doc/BRIEF.md
# Multiprecision Instruction ALU

This block is a registered 16-bit arithmetic logic unit driven by a 5-bit instruction. Each instruction beat carries two operands, an external carry input and three fill bits, and yields one result beat with a carry output. The instruction set covers arithmetic, bitwise logic, constant generation, divide-by-two, flag-mode programming and a master clear.

Words wider than 16 bits are built in two ways. Several units can be chained through the external carry input. Alternatively, one unit can process one 16-bit slice per beat and use its own registered carry. Each arithmetic operation therefore comes with a least-significant-word variant that adds one, a cascade variant and a multicycle variant. The divide-by-two instructions shift the operand right by one bit. The vacated top bit is taken from the sign of the operand or from one of three fill bits, which the surrounding register files supply. The master clear raises a strobe so that neighbouring storage can clear itself.

Instruction beats enter on a valid/ready handshake, and results leave on another. The unit is ready whenever its output register is empty or is being drained in the same cycle. A result that is not taken stays in place and stalls the input.

Top module: `alu_core`

## Requirements
- R1: `in_ready` is high when `out_valid` is low or `out_ready` is high. A beat is accepted on a rising edge where `in_valid` and `in_ready` are both high. After that edge `out_valid` is high. While `out_valid` is high and `out_ready` is low, `out_result`, `carry_out`, `out_clear` and `flag_mode` hold their values, and no beat is accepted.
- R2: The least-significant-word arithmetic codes add a carry of one. Code 0x01 gives ~A+1, code 0x0A gives A+~B+1 and code 0x0D gives ~A+B+1. The 16-bit sum goes to `out_result` and the carry from bit 15 goes to `carry_out`.
- R3: The cascade codes add `carry_in`. Code 0x02 gives ~A, code 0x08 gives A+B, code 0x0B gives A+~B and code 0x0E gives ~A+B.
- R4: The multicycle codes 0x03, 0x09, 0x0C and 0x0F compute the same sums as 0x02, 0x08, 0x0B and 0x0E. They add the carry register instead of `carry_in`. The carry register holds the carry output of the last accepted beat and is visible on `carry_out`.
- R5: The divide-by-two codes output {fill, A[15:1]}. The fill bit is A[15] for code 0x04, `fill_left` for 0x05, `fill_right` for 0x06 and `fill_shift` for 0x07.
- R6: The logic codes 0x10 to 0x17 give, in order: A&B, A&~B, ~A&B, A|B, ~A|B, A^B, A and ~A.
- R7: The constant codes give 0x0001 for 0x1C, 0x00FF for 0x1D, 0x000F for 0x1E and 0x5555 for 0x1F.
- R8: Codes 0x18 to 0x1B output zero and set `flag_mode` to the two low code bits: 0 = overflow, 1 = within a factor of two of overflow, 2 = within a factor of four of overflow, 3 = zero result.
- R9: Code 0x00 outputs zero, clears the carry register, sets `flag_mode` to 0 and raises `out_clear` for that result beat only.
- R10: Logic, constant, divide-by-two, flag-mode and clear beats have a carry output of 0.
- R11: After reset, `out_valid`, `carry_out`, `out_clear` and `flag_mode` are 0 and `out_result` is 0.
- R12: Four beats produce the 64-bit sum and difference of two operands when issued least significant word first. The sum uses code 0x08 with `carry_in` = 0, then 0x09 three times. The difference uses 0x0A, then 0x0C three times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Instruction beat present |
| in_ready | output | 1 | Unit can accept a beat |
| in_op | input | 5 | Instruction code |
| in_a | input | 16 | Operand A |
| in_b | input | 16 | Operand B |
| carry_in | input | 1 | External carry for cascade codes |
| fill_left | input | 1 | Fill bit for code 0x05 |
| fill_right | input | 1 | Fill bit for code 0x06 |
| fill_shift | input | 1 | Fill bit for code 0x07 |
| out_valid | output | 1 | Result beat present |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 16 | Registered result |
| carry_out | output | 1 | Registered carry (carry register) |
| out_clear | output | 1 | Master clear strobe for this result beat |
| flag_mode | output | 2 | Programmed flag condition |

## Verification
Every result is registered on the edge that accepts its beat. The result, the carry, the flag mode and the clear strobe are therefore due one edge after acceptance. The bench drives each beat at a falling edge and samples the outputs at the next falling edge, halfway between the accepting edge and the following one. Back-to-back beats keep this one-cycle spacing, so the bench checks one beat's result and drives the next beat at the same falling edge. During a stall the bench samples over several falling edges to confirm that the held result does not move until the consumer takes it.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [2:0] {
    K_CLEAR,
    K_ARITH,
    K_HALVE,
    K_LOGIC,
    K_FLAGSET,
    K_CONST
  } op_kind_e;

  typedef enum logic [1:0] {
    CS_ONE,
    CS_EXT,
    CS_REG
  } carry_src_e;

  typedef struct packed {
    op_kind_e   kind;
    logic       inv_a;
    logic       inv_b;
    logic       use_b;
    carry_src_e csrc;
  } op_ctl_t;

endpackage

// File: rtl/alu_decode.sv
module alu_decode
  import alu_pkg::*;
#(
  parameter int OP_W = 5
) (
  input  logic [OP_W-1:0] op,
  output op_ctl_t         ctl
);

  always_comb begin
    ctl = '{kind: K_CLEAR, inv_a: 1'b0, inv_b: 1'b0, use_b: 1'b0, csrc: CS_ONE};
    if (op[4] == 1'b0) begin
      if (op[3:0] == 4'h0) begin
        ctl.kind = K_CLEAR;
      end else if (op[3:2] == 2'b01) begin
        ctl.kind = K_HALVE;
      end else begin
        ctl.kind = K_ARITH;
        unique case (op[3:0])
          4'h1: begin ctl.inv_a = 1'b1; ctl.csrc = CS_ONE; end
          4'h2: begin ctl.inv_a = 1'b1; ctl.csrc = CS_EXT; end
          4'h3: begin ctl.inv_a = 1'b1; ctl.csrc = CS_REG; end
          4'h8: begin ctl.use_b = 1'b1; ctl.csrc = CS_EXT; end
          4'h9: begin ctl.use_b = 1'b1; ctl.csrc = CS_REG; end
          4'hA: begin ctl.use_b = 1'b1; ctl.inv_b = 1'b1; ctl.csrc = CS_ONE; end
          4'hB: begin ctl.use_b = 1'b1; ctl.inv_b = 1'b1; ctl.csrc = CS_EXT; end
          4'hC: begin ctl.use_b = 1'b1; ctl.inv_b = 1'b1; ctl.csrc = CS_REG; end
          4'hD: begin ctl.use_b = 1'b1; ctl.inv_a = 1'b1; ctl.csrc = CS_ONE; end
          4'hE: begin ctl.use_b = 1'b1; ctl.inv_a = 1'b1; ctl.csrc = CS_EXT; end
          default: begin ctl.use_b = 1'b1; ctl.inv_a = 1'b1; ctl.csrc = CS_REG; end
        endcase
      end
    end else begin
      unique case (op[3:2])
        2'b10:   ctl.kind = K_FLAGSET;
        2'b11:   ctl.kind = K_CONST;
        default: ctl.kind = K_LOGIC;
      endcase
    end
  end

endmodule

// File: rtl/alu_adder.sv
module alu_adder #(
  parameter int W = 16
) (
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic         inv_a,
  input  logic         inv_b,
  input  logic         use_b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);

  logic [W-1:0] x, y;
  logic [W:0]   total;

  always_comb begin
    x     = inv_a ? ~opa : opa;
    y     = use_b ? (inv_b ? ~opb : opb) : '0;
    total = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};
    sum   = total[W-1:0];
    cout  = total[W];
  end

endmodule

// File: rtl/alu_bitops.sv
module alu_bitops #(
  parameter int W = 16
) (
  input  logic [4:0]   op,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic         fill_left,
  input  logic         fill_right,
  input  logic         fill_shift,
  output logic [W-1:0] logic_res,
  output logic [W-1:0] halve_res,
  output logic [W-1:0] const_res
);

  localparam int BYTE_W = (W < 8) ? W : 8;
  localparam int NIB_W  = (W < 4) ? W : 4;

  logic [W-1:0] k_one, k_byte, k_nib, k_alt;

  for (genvar i = 0; i < W; i++) begin : g_const
    assign k_one[i]  = (i == 0);
    assign k_byte[i] = (i < BYTE_W);
    assign k_nib[i]  = (i < NIB_W);
    assign k_alt[i]  = ((i % 2) == 0);
  end

  logic fill;

  always_comb begin
    unique case (op[2:0])
      3'd0:    logic_res = opa & opb;
      3'd1:    logic_res = opa & ~opb;
      3'd2:    logic_res = ~opa & opb;
      3'd3:    logic_res = opa | opb;
      3'd4:    logic_res = ~opa | opb;
      3'd5:    logic_res = opa ^ opb;
      3'd6:    logic_res = opa;
      default: logic_res = ~opa;
    endcase

    unique case (op[1:0])
      2'd0:    fill = opa[W-1];
      2'd1:    fill = fill_left;
      2'd2:    fill = fill_right;
      default: fill = fill_shift;
    endcase
    halve_res = {fill, opa[W-1:1]};

    unique case (op[1:0])
      2'd0:    const_res = k_one;
      2'd1:    const_res = k_byte;
      2'd2:    const_res = k_nib;
      default: const_res = k_alt;
    endcase
  end

endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
#(
  parameter int W    = 16,
  parameter int OP_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [OP_W-1:0] in_op,
  input  logic [W-1:0]    in_a,
  input  logic [W-1:0]    in_b,
  input  logic            carry_in,
  input  logic            fill_left,
  input  logic            fill_right,
  input  logic            fill_shift,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [W-1:0]    out_result,
  output logic            carry_out,
  output logic            out_clear,
  output logic [1:0]      flag_mode
);

  op_ctl_t      ctl;
  logic         accept;
  logic         add_cin;
  logic [W-1:0] add_sum, logic_res, halve_res, const_res;
  logic         add_cout;
  logic [W-1:0] next_res;
  logic         next_cy;
  logic         carry_q;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  alu_decode #(.OP_W(OP_W)) u_dec (
    .op  (in_op),
    .ctl (ctl)
  );

  always_comb begin
    unique case (ctl.csrc)
      CS_EXT:  add_cin = carry_in;
      CS_REG:  add_cin = carry_q;
      default: add_cin = 1'b1;
    endcase
  end

  alu_adder #(.W(W)) u_add (
    .opa   (in_a),
    .opb   (in_b),
    .inv_a (ctl.inv_a),
    .inv_b (ctl.inv_b),
    .use_b (ctl.use_b),
    .cin   (add_cin),
    .sum   (add_sum),
    .cout  (add_cout)
  );

  alu_bitops #(.W(W)) u_bits (
    .op         (in_op[4:0]),
    .opa        (in_a),
    .opb        (in_b),
    .fill_left  (fill_left),
    .fill_right (fill_right),
    .fill_shift (fill_shift),
    .logic_res  (logic_res),
    .halve_res  (halve_res),
    .const_res  (const_res)
  );

  always_comb begin
    next_cy = 1'b0;
    unique case (ctl.kind)
      K_ARITH: begin next_res = add_sum; next_cy = add_cout; end
      K_HALVE: next_res = halve_res;
      K_LOGIC: next_res = logic_res;
      K_CONST: next_res = const_res;
      default: next_res = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      carry_q    <= 1'b0;
      out_clear  <= 1'b0;
      flag_mode  <= 2'd0;
    end else begin
      if (accept) begin
        out_valid  <= 1'b1;
        out_result <= next_res;
        carry_q    <= next_cy;
        out_clear  <= (ctl.kind == K_CLEAR);
        if (ctl.kind == K_CLEAR)   flag_mode <= 2'd0;
        if (ctl.kind == K_FLAGSET) flag_mode <= in_op[1:0];
      end else if (out_ready) begin
        out_valid <= 1'b0;
        out_clear <= 1'b0;
      end
    end
  end

  assign carry_out = carry_q;

  AST_ACCEPT_GIVES_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid);  // R1
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result) && $stable(carry_out)
                                   && $stable(flag_mode)));  // R1
  AST_NONARITH_NO_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_op[4]) |=> !carry_out);  // R10
  AST_FLAGSET_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_op[4:2] == 3'b110) |=> (out_result == '0 && flag_mode == $past(in_op[1:0])));  // R8
  AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_op == '0) |=> (out_result == '0 && !carry_out && flag_mode == 2'd0 && out_clear));  // R9
  AST_CLEAR_ONE_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_op != '0) |=> !out_clear);  // R9

endmodule

// File: tb/alu_core_tb.sv
module alu_core_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [4:0]  in_op = '0;
  logic [15:0] in_a = '0, in_b = '0;
  logic        carry_in = 1'b0, fill_left = 1'b0, fill_right = 1'b0, fill_shift = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [15:0] out_result;
  logic        carry_out, out_clear;
  logic [1:0]  flag_mode;

  int total = 0;
  int bad = 0;
  logic       cy_m = 1'b0;
  logic [1:0] fm_m = 2'd0;

  always #10 clk = ~clk;

  alu_core u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_a(in_a), .in_b(in_b), .carry_in(carry_in),
    .fill_left(fill_left), .fill_right(fill_right), .fill_shift(fill_shift),
    .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result),
    .carry_out(carry_out), .out_clear(out_clear), .flag_mode(flag_mode)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic string req_of(input logic [4:0] op);
    if (op == 5'h00) return "R9";
    if (op inside {5'h01, 5'h0A, 5'h0D}) return "R2";
    if (op inside {5'h02, 5'h08, 5'h0B, 5'h0E}) return "R3";
    if (op inside {5'h03, 5'h09, 5'h0C, 5'h0F}) return "R4";
    if (op[4:2] == 3'b001) return "R5";
    if (op[4:3] == 2'b10) return "R6";
    if (op[4:2] == 3'b110) return "R8";
    return "R7";
  endfunction

  function automatic logic [16:0] model(input logic [4:0] op, input logic [15:0] a, b,
                                        input logic ci, cy, fl, fr, fs);
    case (op)
      5'h01: return {1'b0, ~a} + 17'd1;
      5'h02: return {1'b0, ~a} + 17'(ci);
      5'h03: return {1'b0, ~a} + 17'(cy);
      5'h04: return {1'b0, a[15], a[15:1]};
      5'h05: return {1'b0, fl, a[15:1]};
      5'h06: return {1'b0, fr, a[15:1]};
      5'h07: return {1'b0, fs, a[15:1]};
      5'h08: return {1'b0, a} + {1'b0, b} + 17'(ci);
      5'h09: return {1'b0, a} + {1'b0, b} + 17'(cy);
      5'h0A: return {1'b0, a} + {1'b0, ~b} + 17'd1;
      5'h0B: return {1'b0, a} + {1'b0, ~b} + 17'(ci);
      5'h0C: return {1'b0, a} + {1'b0, ~b} + 17'(cy);
      5'h0D: return {1'b0, ~a} + {1'b0, b} + 17'd1;
      5'h0E: return {1'b0, ~a} + {1'b0, b} + 17'(ci);
      5'h0F: return {1'b0, ~a} + {1'b0, b} + 17'(cy);
      5'h10: return {1'b0, a & b};
      5'h11: return {1'b0, a & ~b};
      5'h12: return {1'b0, ~a & b};
      5'h13: return {1'b0, a | b};
      5'h14: return {1'b0, ~a | b};
      5'h15: return {1'b0, a ^ b};
      5'h16: return {1'b0, a};
      5'h17: return {1'b0, ~a};
      5'h1C: return 17'h00001;
      5'h1D: return 17'h000FF;
      5'h1E: return 17'h0000F;
      5'h1F: return 17'h05555;
      default: return 17'h0;
    endcase
  endfunction

  // Called at a falling edge; accepted at the next rising edge; checked at the falling edge after.
  task automatic beat(input logic [4:0] op, input logic [15:0] a, b,
                      input logic ci, fl, fr, fs, output logic [15:0] res, output logic co);
    logic [16:0] e;
    string r;
    in_op = op; in_a = a; in_b = b; carry_in = ci;
    fill_left = fl; fill_right = fr; fill_shift = fs; in_valid = 1'b1;
    e = model(op, a, b, ci, cy_m, fl, fr, fs);
    cy_m = e[16];
    if (op == 5'h00) fm_m = 2'd0;
    if (op[4:2] == 3'b110) fm_m = op[1:0];
    r = req_of(op);
    @(negedge clk);
    res = out_result;
    co  = carry_out;
    check(out_valid, "R1", "out_valid after accept", 32'(out_valid), 32'd1);
    check(out_result == e[15:0], r, $sformatf("result op=%h a=%h b=%h", op, a, b),
          32'(out_result), 32'(e[15:0]));
    check(carry_out == e[16], (op[4] || op[3:2] == 2'b01 || op == 0) ? "R10" : r,
          $sformatf("carry op=%h", op), 32'(carry_out), 32'(e[16]));
    check(flag_mode == fm_m, (op[4:2] == 3'b110) ? "R8" : "R9", "flag_mode",
          32'(flag_mode), 32'(fm_m));
    check(out_clear == (op == 5'h00), "R9", "clear strobe", 32'(out_clear), 32'(op == 5'h00));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] corner [8];
    logic [15:0] lfsr;
    logic [15:0] r0;
    logic        c0;
    logic [63:0] xa, xb, got;
    logic        clast;

    corner = '{16'h0000, 16'hFFFF, 16'h8000, 16'h7FFF, 16'h0001, 16'h5555, 16'hAAAA, 16'h1234};
    lfsr = 16'hACE1;

    repeat (3) @(negedge clk);
    check(!out_valid && !carry_out && !out_clear && flag_mode == 0 && out_result == 0,
          "R11", "reset state", {out_result, 11'd0, out_valid, carry_out, out_clear, flag_mode},
          32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready, "R1", "ready when empty", 32'(in_ready), 32'd1);

    // Near-exhaustive sweep: every code over corner pairs and pseudo-random operands.
    for (int op = 0; op < 32; op++) begin
      for (int i = 0; i < 8; i++) begin
        for (int j = 0; j < 8; j++) begin
          beat(5'(op), corner[i], corner[j], 1'((i + j) % 2), 1'(i % 2), 1'(j % 2),
               1'((i ^ j) % 2), r0, c0);
        end
      end
      for (int k = 0; k < 40; k++) begin
        logic [15:0] ra, rb;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        ra = lfsr;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        rb = lfsr;
        beat(5'(op), ra, rb, rb[0], ra[1], rb[2], ra[3], r0, c0);
      end
    end
    // Multicycle chains mixed with other codes so the carry register sees varied history.
    for (int k = 0; k < 300; k++) begin
      logic [15:0] ra, rb;
      logic [4:0]  pk;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      ra = lfsr;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      rb = lfsr;
      pk = (k % 3 == 0) ? 5'(ra[4:0]) : ((k % 2 == 0) ? 5'h09 : 5'h0C);
      beat(pk, ra, rb, rb[5], ra[6], rb[7], ra[8], r0, c0);
    end

    // R12: 64-bit add and subtract over four beats, least significant word first.
    for (int t = 0; t < 6; t++) begin
      xa = {corner[t], corner[t + 2], corner[7 - t], 16'(t * 4099)};
      xb = {corner[7 - t], corner[t + 1], 16'(t * 771), corner[t]};
      for (int w = 0; w < 4; w++) begin
        beat(w == 0 ? 5'h08 : 5'h09, xa[w*16 +: 16], xb[w*16 +: 16], 1'b0, 1'b0, 1'b0, 1'b0, r0, c0);
        got[w*16 +: 16] = r0;
        clast = c0;
      end
      check(got == xa + xb, "R12", "64-bit sum", got[31:0], 32'(xa + xb));
      check(clast == (({1'b0, xa} + {1'b0, xb}) >> 64), "R12", "64-bit sum carry",
            32'(clast), 32'(({1'b0, xa} + {1'b0, xb}) >> 64));
      for (int w = 0; w < 4; w++) begin
        beat(w == 0 ? 5'h0A : 5'h0C, xa[w*16 +: 16], xb[w*16 +: 16], 1'b1, 1'b0, 1'b0, 1'b0, r0, c0);
        got[w*16 +: 16] = r0;
      end
      check(got == xa - xb, "R12", "64-bit difference", got[63:32], 32'((xa - xb) >> 32));
    end

    // R1: back-pressure holds the result and blocks the next beat.
    beat(5'h1F, 16'h0, 16'h0, 1'b0, 1'b0, 1'b0, 1'b0, r0, c0);
    out_ready = 1'b0;
    in_op = 5'h1C; in_a = 16'h0; in_b = 16'h0; in_valid = 1'b1;
    @(negedge clk);
    check(!in_ready, "R1", "not ready while stalled", 32'(in_ready), 32'd0);
    for (int s = 0; s < 3; s++) begin
      @(negedge clk);
      check(out_valid && out_result == 16'h5555, "R1", "held result during stall",
            32'(out_result), 32'h5555);
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid && out_result == 16'h0001, "R1", "stalled beat accepted once",
          32'(out_result), 32'h0001);
    @(negedge clk);
    check(!out_valid, "R1", "drained with no further beat", 32'(out_valid), 32'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule